// File: doc/BRIEF.md
# Dual GPIO Port with Pin-Level Resolution

This block is a memory-mapped general-purpose I/O unit with two 16-pin ports, A and B. Each port has a control word, which gives every pin an output-enable bit and a pull-up enable bit, and a data word. An on-chip peripheral can also drive each port through its own direction and value vectors. The block combines the processor's drive, the peripheral's drive and the pull-ups into one resolved level per pin, and these levels appear on the pin outputs.

A read of a port's data address returns the resolved levels, not the value last written. An accepted write to a port's control or data word compares the resolved levels of that port before and after the update. A number of listener slots each hold a trigger mask per port. A listener whose mask overlaps the changed pins gets a one-cycle notify pulse, and the new resolved levels of both ports are given with it. An interrupt-control word takes any value and can be read back, but it never raises an interrupt.

Top module: `dual_gpio_resolver`

## Requirements
- R1: After synchronous reset, all control, data and interrupt-control words are zero. With the peripheral not driving, both ports' pins read 0 and no notify bit is set.
- R2: In a control word, bit 2n is the output-enable of pin n and bit 2n+1 is the pull-up enable of pin n, for n from 0 to 15.
- R3: Each resolved pin level is (cpu_en & cpu_data) | (ext_dir & ext_val) | (~(cpu_en | ext_dir) & pullup). An enabled output therefore masks its own pull-up.
- R4: A word read of a data address (A at 0x04, B at 0x0C) returns the port's resolved levels in bits 15:0 and zero above them.
- R5: A long read of a control address (A at 0x00, B at 0x08) returns the stored 32-bit control word.
- R6: An accepted write sets notify[i] for exactly one cycle, the cycle after the write. It does so when listener i's mask for the written port (mask_a or mask_b, slot i in bits 16i+15:16i) ANDed with the before/after change vector is non-zero. No other event sets notify.
- R7: A write that leaves every resolved level of the port unchanged produces no notify pulse.
- R8: Together with a notify pulse, notify_pins_a and notify_pins_b carry the resolved levels of both ports as they are after the write.
- R9: bus_size encodes 0 = byte, 1 = word (16 bits), 2 = long (32 bits). Data and interrupt-control addresses accept only word accesses and control addresses accept only long accesses. Any other width, or an unmapped address, sets bus_err, returns zero read data and changes no state.
- R10: A word write to the interrupt-control address (0x10) stores any 16-bit value, which a word read returns. It raises no notify.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access width: 0 byte, 1 word, 2 long |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| bus_err | output | 1 | Access width or address not supported |
| pa_ext_dir | input | 16 | Peripheral drive enables for port A |
| pa_ext_val | input | 16 | Peripheral drive values for port A |
| pb_ext_dir | input | 16 | Peripheral drive enables for port B |
| pb_ext_val | input | 16 | Peripheral drive values for port B |
| lsn_mask_a | input | 64 | Per-listener trigger masks, port A |
| lsn_mask_b | input | 64 | Per-listener trigger masks, port B |
| pins_a | output | 16 | Resolved levels of port A |
| pins_b | output | 16 | Resolved levels of port B |
| notify | output | 4 | One-cycle notify pulse per listener |
| notify_pins_a | output | 16 | Port A levels after the notifying write |
| notify_pins_b | output | 16 | Port B levels after the notifying write |

## Verification
The vector walk first drives only the processor's side. It writes control words that set only even bits, then only odd bits, then both on the same pins. This shows whether the interleaved fields are decoded to the right pins, and whether an enabled output hides its pull-up. Data writes with all ones against partial output-enables show that reads return resolved levels rather than stored bits. Writes that leave the levels unchanged are placed next to writes whose changes hit only some masks, so a missing change gate or a wrong mask mapping leaves a wrong notify pattern. Directed steps then add peripheral drive under pull-ups and check the one-cycle pulse width. They also run every illegal access width and show that each such access leaves the stored state untouched.

// File: rtl/gpio_res_pkg.sv
package gpio_res_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2
    } acc_size_e;

    // Register byte offsets
    localparam int OFF_CTRL_A = 'h00;
    localparam int OFF_DATA_A = 'h04;
    localparam int OFF_CTRL_B = 'h08;
    localparam int OFF_DATA_B = 'h0C;
    localparam int OFF_IOIC   = 'h10;

    localparam int NUM_PORTS = 2;

    typedef struct packed {
        logic [NUM_PORTS-1:0] ctrl;
        logic [NUM_PORTS-1:0] data;
        logic                 ioic;
        logic                 ok;
    } dec_hit_t;

endpackage

// File: rtl/gpio_port_unit.sv
module gpio_port_unit #(
    parameter int PIN_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ctrl_we,
    input  logic                 data_we,
    input  logic [2*PIN_W-1:0]   wdata,
    input  logic [PIN_W-1:0]     ext_dir,
    input  logic [PIN_W-1:0]     ext_val,
    output logic [2*PIN_W-1:0]   ctrl_q,
    output logic [PIN_W-1:0]     level_now,
    output logic [PIN_W-1:0]     level_next,
    output logic [PIN_W-1:0]     change
);
    localparam int CTRL_W = 2 * PIN_W;

    logic [PIN_W-1:0]  data_q;
    logic [CTRL_W-1:0] ctrl_nx;
    logic [PIN_W-1:0]  data_nx;
    logic [PIN_W-1:0]  en_now, pu_now, en_nx, pu_nx;

    assign ctrl_nx = ctrl_we ? wdata : ctrl_q;
    assign data_nx = data_we ? wdata[PIN_W-1:0] : data_q;

    // Split the interleaved control word: even bits enable, odd bits pull-up
    for (genvar n = 0; n < PIN_W; n++) begin : g_split
        assign en_now[n] = ctrl_q[2*n];
        assign pu_now[n] = ctrl_q[2*n+1];
        assign en_nx[n]  = ctrl_nx[2*n];
        assign pu_nx[n]  = ctrl_nx[2*n+1];
    end

    assign level_now  = (en_now & data_q) | (ext_dir & ext_val)
                      | (~(en_now | ext_dir) & pu_now);
    assign level_next = (en_nx & data_nx) | (ext_dir & ext_val)
                      | (~(en_nx | ext_dir) & pu_nx);
    assign change     = level_now ^ level_next;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            data_q <= '0;
        end else begin
            ctrl_q <= ctrl_nx;
            data_q <= data_nx;
        end
    end
endmodule

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
    import gpio_res_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              bus_valid,
    input  logic [1:0]        bus_size,
    input  logic [ADDR_W-1:0] bus_addr,
    output dec_hit_t          hit
);
    logic is_word, is_long;
    logic a_ctrl_a, a_ctrl_b, a_data_a, a_data_b, a_ioic;

    assign is_word  = (bus_size == SZ_WORD);
    assign is_long  = (bus_size == SZ_LONG);
    assign a_ctrl_a = (bus_addr == ADDR_W'(OFF_CTRL_A));
    assign a_ctrl_b = (bus_addr == ADDR_W'(OFF_CTRL_B));
    assign a_data_a = (bus_addr == ADDR_W'(OFF_DATA_A));
    assign a_data_b = (bus_addr == ADDR_W'(OFF_DATA_B));
    assign a_ioic   = (bus_addr == ADDR_W'(OFF_IOIC));

    always_comb begin
        hit.ctrl = {a_ctrl_b, a_ctrl_a} & {2{bus_valid & is_long}};
        hit.data = {a_data_b, a_data_a} & {2{bus_valid & is_word}};
        hit.ioic = a_ioic & bus_valid & is_word;
        hit.ok   = (|hit.ctrl) | (|hit.data) | hit.ioic;
    end
endmodule

// File: rtl/gpio_notify_unit.sv
module gpio_notify_unit #(
    parameter int PIN_W   = 16,
    parameter int NUM_LSN = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     fire,
    input  logic [PIN_W-1:0]         chg_a,
    input  logic [PIN_W-1:0]         chg_b,
    input  logic [PIN_W-1:0]         lvl_a_next,
    input  logic [PIN_W-1:0]         lvl_b_next,
    input  logic [NUM_LSN*PIN_W-1:0] mask_a,
    input  logic [NUM_LSN*PIN_W-1:0] mask_b,
    output logic [NUM_LSN-1:0]       notify,
    output logic [PIN_W-1:0]         lvl_a_o,
    output logic [PIN_W-1:0]         lvl_b_o
);
    logic [NUM_LSN-1:0] hit;

    for (genvar i = 0; i < NUM_LSN; i++) begin : g_lsn
        assign hit[i] = |(mask_a[i*PIN_W +: PIN_W] & chg_a)
                      | |(mask_b[i*PIN_W +: PIN_W] & chg_b);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            notify  <= '0;
            lvl_a_o <= '0;
            lvl_b_o <= '0;
        end else begin
            notify <= fire ? hit : '0;
            if (fire) begin
                lvl_a_o <= lvl_a_next;
                lvl_b_o <= lvl_b_next;
            end
        end
    end
endmodule

// File: rtl/dual_gpio_resolver.sv
module dual_gpio_resolver
    import gpio_res_pkg::*;
#(
    parameter int PIN_W   = 16,
    parameter int NUM_LSN = 4,
    parameter int ADDR_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_valid,
    input  logic                     bus_write,
    input  logic [1:0]               bus_size,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [2*PIN_W-1:0]       bus_wdata,
    output logic [2*PIN_W-1:0]       bus_rdata,
    output logic                     bus_err,
    input  logic [PIN_W-1:0]         pa_ext_dir,
    input  logic [PIN_W-1:0]         pa_ext_val,
    input  logic [PIN_W-1:0]         pb_ext_dir,
    input  logic [PIN_W-1:0]         pb_ext_val,
    input  logic [NUM_LSN*PIN_W-1:0] lsn_mask_a,
    input  logic [NUM_LSN*PIN_W-1:0] lsn_mask_b,
    output logic [PIN_W-1:0]         pins_a,
    output logic [PIN_W-1:0]         pins_b,
    output logic [NUM_LSN-1:0]       notify,
    output logic [PIN_W-1:0]         notify_pins_a,
    output logic [PIN_W-1:0]         notify_pins_b
);
    localparam int CTRL_W = 2 * PIN_W;

    dec_hit_t    hit;
    logic        fire;
    logic [PIN_W-1:0]  ioic_q;
    logic [PIN_W-1:0]  ext_dir [NUM_PORTS];
    logic [PIN_W-1:0]  ext_val [NUM_PORTS];
    logic [CTRL_W-1:0] ctrl_q  [NUM_PORTS];
    logic [PIN_W-1:0]  lvl_now [NUM_PORTS];
    logic [PIN_W-1:0]  lvl_nx  [NUM_PORTS];
    logic [PIN_W-1:0]  chg     [NUM_PORTS];

    assign ext_dir[0] = pa_ext_dir;
    assign ext_dir[1] = pb_ext_dir;
    assign ext_val[0] = pa_ext_val;
    assign ext_val[1] = pb_ext_val;

    gpio_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_valid (bus_valid),
        .bus_size  (bus_size),
        .bus_addr  (bus_addr),
        .hit       (hit)
    );

    assign bus_err = bus_valid & ~hit.ok;
    assign fire    = bus_write & hit.ok;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        gpio_port_unit #(.PIN_W(PIN_W)) u_port (
            .clk        (clk),
            .rst        (rst),
            .ctrl_we    (bus_write & hit.ctrl[p]),
            .data_we    (bus_write & hit.data[p]),
            .wdata      (bus_wdata),
            .ext_dir    (ext_dir[p]),
            .ext_val    (ext_val[p]),
            .ctrl_q     (ctrl_q[p]),
            .level_now  (lvl_now[p]),
            .level_next (lvl_nx[p]),
            .change     (chg[p])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            ioic_q <= '0;
        else if (bus_write && hit.ioic)
            ioic_q <= bus_wdata[PIN_W-1:0];
    end

    always_comb begin
        bus_rdata = '0;
        if (!bus_write) begin
            if (hit.ctrl[0]) bus_rdata = ctrl_q[0];
            if (hit.ctrl[1]) bus_rdata = ctrl_q[1];
            if (hit.data[0]) bus_rdata = CTRL_W'(lvl_now[0]);
            if (hit.data[1]) bus_rdata = CTRL_W'(lvl_now[1]);
            if (hit.ioic)    bus_rdata = CTRL_W'(ioic_q);
        end
    end

    assign pins_a = lvl_now[0];
    assign pins_b = lvl_now[1];

    gpio_notify_unit #(.PIN_W(PIN_W), .NUM_LSN(NUM_LSN)) u_ntf (
        .clk        (clk),
        .rst        (rst),
        .fire       (fire),
        .chg_a      (chg[0]),
        .chg_b      (chg[1]),
        .lvl_a_next (lvl_nx[0]),
        .lvl_b_next (lvl_nx[1]),
        .mask_a     (lsn_mask_a),
        .mask_b     (lsn_mask_b),
        .notify     (notify),
        .lvl_a_o    (notify_pins_a),
        .lvl_b_o    (notify_pins_b)
    );
endmodule

// File: rtl/gpio_res_checker.sv
module gpio_res_checker #(
    parameter int PIN_W   = 16,
    parameter int NUM_LSN = 4,
    parameter int ADDR_W  = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_valid,
    input logic                 bus_write,
    input logic [1:0]           bus_size,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [2*PIN_W-1:0]   bus_rdata,
    input logic                 bus_err,
    input logic [PIN_W-1:0]     pins_a,
    input logic [NUM_LSN-1:0]   notify
);
    // R6: a pulse needs an accepted write in the previous cycle
    a_r6_notify_after_write: assert property (@(posedge clk) disable iff (rst)
        (|notify) |-> $past(bus_valid && bus_write && !bus_err));

    // R9: a rejected write never notifies
    a_r9_err_no_notify: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && bus_err) |=> (notify == '0));

    // R6: a read never notifies
    a_r6_read_no_notify: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write) |=> (notify == '0));

    // R9: byte accesses are always rejected with zero read data
    a_r9_byte_err: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_size == 2'd0) |-> (bus_err && bus_rdata == '0));

    // R4: data read of port A matches the pin outputs
    a_r4_read_is_pins: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && bus_size == 2'd1 && bus_addr == ADDR_W'(4))
        |-> (bus_rdata == (2*PIN_W)'(pins_a)));
endmodule

bind dual_gpio_resolver gpio_res_checker #(
    .PIN_W(PIN_W), .NUM_LSN(NUM_LSN), .ADDR_W(ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_size  (bus_size),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .pins_a    (pins_a),
    .notify    (notify)
);

// File: tb/dual_gpio_resolver_bench.sv
module dual_gpio_resolver_bench;
    localparam int PIN_W = 16;
    localparam int NL    = 4;

    typedef struct packed {
        logic        wr;
        logic [1:0]  sz;
        logic [7:0]  addr;
        logic [31:0] wd;
        logic [31:0] rd;
        logic        err;
        logic [3:0]  ntf;
        logic [15:0] la;
        logic [15:0] lb;
    } vec_t;

    // sz: 0 byte, 1 word, 2 long. Masks: L0 a=0001, L1 a=FF00, L2 b=00F0, L3 a,b=FFFF
    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd1, 8'h04, 32'h0,         32'h0,         1'b0, 4'h0, 16'h0,    16'h0},    // R1 data A
        '{1'b0, 2'd2, 8'h00, 32'h0,         32'h0,         1'b0, 4'h0, 16'h0,    16'h0},    // R1 ctrl A
        '{1'b1, 2'd2, 8'h00, 32'h0000_0005, 32'h0,         1'b0, 4'h0, 16'h0,    16'h0},    // R7 enable pins 0,1
        '{1'b1, 2'd1, 8'h04, 32'h0000_FFFF, 32'h0,         1'b0, 4'h9, 16'h0003, 16'h0},    // R6 R8
        '{1'b0, 2'd1, 8'h04, 32'h0,         32'h0000_0003, 1'b0, 4'h0, 16'h0,    16'h0},    // R4 resolved
        '{1'b1, 2'd2, 8'h00, 32'hAAAA_0000, 32'h0,         1'b0, 4'hB, 16'hFF00, 16'h0},    // R2 pull-ups
        '{1'b0, 2'd2, 8'h00, 32'h0,         32'hAAAA_0000, 1'b0, 4'h0, 16'h0,    16'h0},    // R5
        '{1'b0, 2'd1, 8'h04, 32'h0,         32'h0000_FF00, 1'b0, 4'h0, 16'h0,    16'h0},    // R2 R4
        '{1'b1, 2'd2, 8'h00, 32'h5555_0000, 32'h0,         1'b0, 4'h0, 16'h0,    16'h0},    // R7 same levels
        '{1'b1, 2'd1, 8'h04, 32'h0000_00FF, 32'h0,         1'b0, 4'hA, 16'h0000, 16'h0},    // R6
        '{1'b1, 2'd2, 8'h08, 32'h0000_FFFF, 32'h0,         1'b0, 4'h0, 16'h0,    16'h0},    // R3 enable hides pull-up
        '{1'b1, 2'd1, 8'h0C, 32'h0000_0030, 32'h0,         1'b0, 4'hC, 16'h0000, 16'h0030}, // R6 R8 port B
        '{1'b0, 2'd1, 8'h0C, 32'h0,         32'h0000_0030, 1'b0, 4'h0, 16'h0,    16'h0},    // R4 port B
        '{1'b1, 2'd0, 8'h04, 32'h0000_0001, 32'h0,         1'b1, 4'h0, 16'h0,    16'h0},    // R9 byte
        '{1'b1, 2'd1, 8'h00, 32'h0000_0000, 32'h0,         1'b1, 4'h0, 16'h0,    16'h0},    // R9 word to ctrl
        '{1'b0, 2'd1, 8'h00, 32'h0,         32'h0,         1'b1, 4'h0, 16'h0,    16'h0},    // R9
        '{1'b0, 2'd2, 8'h0C, 32'h0,         32'h0,         1'b1, 4'h0, 16'h0,    16'h0},    // R9 long to data
        '{1'b1, 2'd2, 8'h14, 32'hFFFF_FFFF, 32'h0,         1'b1, 4'h0, 16'h0,    16'h0},    // R9 unmapped
        '{1'b1, 2'd1, 8'h10, 32'h0000_BEEF, 32'h0,         1'b0, 4'h0, 16'h0,    16'h0},    // R10
        '{1'b0, 2'd1, 8'h10, 32'h0,         32'h0000_BEEF, 1'b0, 4'h0, 16'h0,    16'h0},    // R10
        '{1'b0, 2'd2, 8'h00, 32'h0,         32'h5555_0000, 1'b0, 4'h0, 16'h0,    16'h0}     // R9 state kept
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_valid = 1'b0, bus_write = 1'b0;
    logic [1:0]  bus_size = 2'd0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic bus_err;
    logic [15:0] pa_ext_dir = '0, pa_ext_val = '0, pb_ext_dir = '0, pb_ext_val = '0;
    logic [NL*PIN_W-1:0] lsn_mask_a = {16'hFFFF, 16'h0000, 16'hFF00, 16'h0001};
    logic [NL*PIN_W-1:0] lsn_mask_b = {16'hFFFF, 16'h00F0, 16'h0000, 16'h0000};
    logic [15:0] pins_a, pins_b, notify_pins_a, notify_pins_b;
    logic [NL-1:0] notify;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    dual_gpio_resolver #(.PIN_W(PIN_W), .NUM_LSN(NL), .ADDR_W(8)) u_dual_gpio_resolver (
        .clk(clk), .rst(rst),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_size(bus_size),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .pa_ext_dir(pa_ext_dir), .pa_ext_val(pa_ext_val),
        .pb_ext_dir(pb_ext_dir), .pb_ext_val(pb_ext_val),
        .lsn_mask_a(lsn_mask_a), .lsn_mask_b(lsn_mask_b),
        .pins_a(pins_a), .pins_b(pins_b), .notify(notify),
        .notify_pins_a(notify_pins_a), .notify_pins_b(notify_pins_b)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Drive one access at a negedge, check the combinational response,
    // then after the edge drop the request and check the notify outputs.
    task automatic access(input logic wr, input logic [1:0] sz, input logic [7:0] ad,
                          input logic [31:0] wd, output logic [31:0] rd, output logic er);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_size = sz; bus_addr = ad; bus_wdata = wd;
        #2;
        rd = bus_rdata;
        er = bus_err;
        @(posedge clk);
        #1;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                fails++;
                $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] rd;
        logic er;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(pins_a == 16'h0, "R1 pins_a after reset", 32'(pins_a), 32'h0);
        chk(pins_b == 16'h0, "R1 pins_b after reset", 32'(pins_b), 32'h0);
        chk(notify == '0,    "R1 notify after reset", 32'(notify), 32'h0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            access(v.wr, v.sz, v.addr, v.wd, rd, er);
            chk(er == v.err, $sformatf("R9 err vector %0d", i), 32'(er), 32'(v.err));
            if (!v.wr)
                chk(rd == v.rd, $sformatf("R4 R5 rdata vector %0d", i), rd, v.rd);
            else begin
                chk(notify == v.ntf, $sformatf("R6 R7 notify vector %0d", i), 32'(notify), 32'(v.ntf));
                if (v.ntf != 0) begin
                    chk(notify_pins_a == v.la, $sformatf("R8 levels A vector %0d", i), 32'(notify_pins_a), 32'(v.la));
                    chk(notify_pins_b == v.lb, $sformatf("R8 levels B vector %0d", i), 32'(notify_pins_b), 32'(v.lb));
                end
            end
        end

        // R3: peripheral drive. Port A: enables FF00, data 00FF, no pull-ups.
        @(negedge clk);
        pa_ext_dir = 16'h000F; pa_ext_val = 16'h0005;
        #1;
        chk(pins_a == 16'h0005, "R3 peripheral drive", 32'(pins_a), 32'h0005);
        chk(pins_b == 16'h0030, "R3 port B levels", 32'(pins_b), 32'h0030);
        @(posedge clk); #1;
        chk(notify == '0, "R6 peripheral change alone", 32'(notify), 32'h0);
        access(1'b0, 2'd1, 8'h04, 32'h0, rd, er);
        chk(rd == 32'h0005, "R3 read with peripheral", rd, 32'h0005);

        // R3: all pull-ups, no enables; peripheral owns pins 3..0
        access(1'b1, 2'd2, 8'h00, 32'hAAAA_AAAA, rd, er);
        chk(notify == 4'hA, "R6 pull-up change notify", 32'(notify), 32'hA);
        chk(notify_pins_a == 16'hFFF5, "R8 levels A", 32'(notify_pins_a), 32'hFFF5);
        chk(notify_pins_b == 16'h0030, "R8 levels B", 32'(notify_pins_b), 32'h0030);
        chk(pins_a == 16'hFFF5, "R3 pull-ups and peripheral", 32'(pins_a), 32'hFFF5);
        @(posedge clk); #1;
        chk(notify == '0, "R6 one-cycle pulse", 32'(notify), 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule